// File: doc/BRIEF.md
# Oscillator-Pair Device Identifier Generator

This block turns the manufacturing spread between pairs of free-running oscillators into a 48-bit word that identifies the silicon it runs on. Each identifier bit owns two oscillator inputs. Each oscillator is slowed by a four-stage toggle divider and then advances an 8-bit counter. A sequencer in the system clock domain clears every divider and counter, lets them all count over the same window, and then freezes them. The frozen counts are carried across to the system clock and compared. A bit is 1 when the first oscillator of its pair counted further than the second. A tie or a smaller count gives 0.

A single request runs three such evaluations back to back. The three results for each bit are reduced by a bitwise two-of-three vote, which smooths out pairs whose frequencies are nearly equal. The voted word is presented on the identifier output together with a one-cycle completion strobe. It stays there until the next generation completes. A request made while a generation is in progress has no effect.

Top module: `puf_id_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `done` is 0 and `id_out` is all zeros.
- R2: When `req` is sampled high at a rising edge while the block is idle, `done` is high for exactly one cycle after the 770th following rising edge, and is low at every other time.
- R3: Within one evaluation, result bit i is 1 when `osc_a[i]` completed more divide-by-16 periods than `osc_b[i]` during the count window. It is 0 when `osc_a[i]` completed fewer.
- R4: When both counts of a pair are equal, that pair's result bit is 0.
- R5: Each generation performs three evaluations of 256 system cycles each. Evaluation r (r = 0, 1, 2) starts at the edge 256*r after the request edge. Within it, the first 16 cycles clear, the next 192 count and the last 48 hold. Bit i of `id_out` is the majority of the three results for bit i.
- R6: `id_out` changes only at the edge that raises `done`, and keeps its value until the next generation completes. A `req` pulse during a generation neither restarts it nor moves its `done`.
- R7: Every evaluation starts from cleared dividers and counters, so counts from an earlier evaluation do not carry into a later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Starts a generation when sampled high while idle |
| osc_a | input | 48 | First oscillator of each bit pair |
| osc_b | input | 48 | Second oscillator of each bit pair |
| done | output | 1 | One-cycle strobe marking a new identifier |
| id_out | output | 48 | Voted device identifier |

## Verification
The strobe and the new identifier are due together, after the 770th rising edge that follows the request edge. The reference model counts edges from the request and predicts both outputs for every cycle. The outputs are compared on each falling edge, away from the active edge. Oscillator periods are changed only at fixed offsets of 260 and 516 edges after the request. These fall inside the clear phase of evaluations 1 and 2, so each evaluation sees a known, well separated pair of rates. A second request is pulsed one edge after the 260 offset, during a generation, to show that the strobe still arrives at edge 770 of the first request.

// File: rtl/puf_pkg.sv
`timescale 1ps/1ps
package puf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_VOTE,
        ST_FIN
    } ctrl_state_e;

    typedef struct packed {
        logic clr;
        logic en;
    } lane_cmd_t;

    localparam int unsigned RUN_COUNT = 3;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic lane_cmd_t phase_decode(input int unsigned pos,
                                               input int unsigned clr_len,
                                               input int unsigned cnt_len);
        lane_cmd_t c;
        c.clr = (pos < clr_len);
        c.en  = (pos >= clr_len) && (pos < clr_len + cnt_len);
        return c;
    endfunction

endpackage

// File: rtl/puf_osc_lane.sv
`timescale 1ps/1ps
module puf_osc_lane
    import puf_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned DIV_STAGES  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             osc,
    input  lane_cmd_t        cmd,
    output logic [CNT_W-1:0] count
);

    logic [SYNC_STAGES-1:0] clr_s;
    logic [SYNC_STAGES-1:0] en_s;
    logic [DIV_STAGES-1:0]  div_q;
    logic [DIV_STAGES-1:0]  tog;
    logic                   tick;

    // Toggle chain: stage i flips when every lower stage is high.
    assign tog[0] = 1'b1;
    for (genvar i = 1; i < DIV_STAGES; i++) begin : g_tog
        assign tog[i] = &div_q[i-1:0];
    end

    // Last stage about to rise: one divided period completed.
    assign tick = tog[DIV_STAGES-1] & ~div_q[DIV_STAGES-1];

    always_ff @(posedge osc) begin
        clr_s <= {clr_s[SYNC_STAGES-2:0], cmd.clr};
        en_s  <= {en_s[SYNC_STAGES-2:0], cmd.en};
        if (clr_s[SYNC_STAGES-1]) begin
            div_q <= '0;
            count <= '0;
        end else if (en_s[SYNC_STAGES-1]) begin
            div_q <= div_q ^ tog;
            if (tick) begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/puf_bit_cell.sv
`timescale 1ps/1ps
module puf_bit_cell
    import puf_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned DIV_STAGES  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      osc_a,
    input  logic      osc_b,
    input  lane_cmd_t cmd,
    output logic      above
);

    logic [CNT_W-1:0] cnt_a;
    logic [CNT_W-1:0] cnt_b;
    logic [CNT_W-1:0] sync_a [SYNC_STAGES];
    logic [CNT_W-1:0] sync_b [SYNC_STAGES];

    puf_osc_lane #(
        .CNT_W(CNT_W), .DIV_STAGES(DIV_STAGES), .SYNC_STAGES(SYNC_STAGES)
    ) lane_a_i (
        .osc(osc_a), .cmd(cmd), .count(cnt_a)
    );

    puf_osc_lane #(
        .CNT_W(CNT_W), .DIV_STAGES(DIV_STAGES), .SYNC_STAGES(SYNC_STAGES)
    ) lane_b_i (
        .osc(osc_b), .cmd(cmd), .count(cnt_b)
    );

    // Counts are frozen before capture, so a plain multi-bit synchroniser is safe.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_STAGES; s++) begin
                sync_a[s] <= '0;
                sync_b[s] <= '0;
            end
        end else begin
            sync_a[0] <= cnt_a;
            sync_b[0] <= cnt_b;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                sync_a[s] <= sync_a[s-1];
                sync_b[s] <= sync_b[s-1];
            end
        end
    end

    // Strict comparison: equal counts give 0.
    assign above = sync_a[SYNC_STAGES-1] > sync_b[SYNC_STAGES-1];

endmodule

// File: rtl/puf_seq_ctrl.sv
`timescale 1ps/1ps
module puf_seq_ctrl
    import puf_pkg::*;
#(
    parameter int unsigned CLR_CYC  = 16,
    parameter int unsigned CNT_CYC  = 192,
    parameter int unsigned HOLD_CYC = 48,
    localparam int unsigned EVAL_LEN = CLR_CYC + CNT_CYC + HOLD_CYC,
    localparam int unsigned POS_W    = $clog2(EVAL_LEN)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    output lane_cmd_t  cmd_q,
    output logic       capture,
    output logic [1:0] run_idx,
    output logic       vote_en,
    output logic       finish
);

    ctrl_state_e      state;
    logic [POS_W-1:0] pos;
    logic             eval_end;

    assign eval_end = (state == ST_RUN) && (pos == POS_W'(EVAL_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pos     <= '0;
            run_idx <= '0;
            cmd_q   <= '{clr: 1'b1, en: 1'b0};
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        state   <= ST_RUN;
                        pos     <= '0;
                        run_idx <= '0;
                    end
                end
                ST_RUN: begin
                    if (eval_end) begin
                        pos <= '0;
                        if (run_idx == 2'(RUN_COUNT - 1)) begin
                            state <= ST_VOTE;
                        end else begin
                            run_idx <= run_idx + 1'b1;
                        end
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                ST_VOTE: state <= ST_FIN;
                default: state <= ST_IDLE;
            endcase

            if (state == ST_RUN) begin
                cmd_q <= phase_decode(int'(pos), CLR_CYC, CNT_CYC);
            end else begin
                cmd_q <= '{clr: 1'b1, en: 1'b0};
            end
        end
    end

    assign capture = eval_end;
    assign vote_en = (state == ST_VOTE);
    assign finish  = (state == ST_FIN);

endmodule

// File: rtl/puf_id_ctrl.sv
`timescale 1ps/1ps
module puf_id_ctrl
    import puf_pkg::*;
#(
    parameter int unsigned ID_W        = 48,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned DIV_STAGES  = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CLR_CYC     = 16,
    parameter int unsigned CNT_CYC     = 192,
    parameter int unsigned HOLD_CYC    = 48
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [ID_W-1:0] osc_a,
    input  logic [ID_W-1:0] osc_b,
    output logic            done,
    output logic [ID_W-1:0] id_out
);

    lane_cmd_t       cmd;
    logic            capture;
    logic [1:0]      run_idx;
    logic            vote_en;
    logic            finish;
    logic            clr_w;
    logic            en_w;
    logic [ID_W-1:0] cell_bits;
    logic [ID_W-1:0] run_bits [RUN_COUNT];
    logic [ID_W-1:0] maj_w;
    logic [ID_W-1:0] vote_q;

    puf_seq_ctrl #(
        .CLR_CYC(CLR_CYC), .CNT_CYC(CNT_CYC), .HOLD_CYC(HOLD_CYC)
    ) ctrl_i (
        .clk(clk), .rst(rst), .req(req), .cmd_q(cmd), .capture(capture),
        .run_idx(run_idx), .vote_en(vote_en), .finish(finish)
    );

    assign clr_w = cmd.clr;
    assign en_w  = cmd.en;

    for (genvar i = 0; i < ID_W; i++) begin : g_cell
        puf_bit_cell #(
            .CNT_W(CNT_W), .DIV_STAGES(DIV_STAGES), .SYNC_STAGES(SYNC_STAGES)
        ) cell_i (
            .clk(clk), .rst(rst), .osc_a(osc_a[i]), .osc_b(osc_b[i]),
            .cmd(cmd), .above(cell_bits[i])
        );
        assign maj_w[i] = maj3(run_bits[0][i], run_bits[1][i], run_bits[2][i]);
    end

    for (genvar r = 0; r < RUN_COUNT; r++) begin : g_run
        always_ff @(posedge clk) begin
            if (rst) begin
                run_bits[r] <= '0;
            end else if (capture && (run_idx == 2'(r))) begin
                run_bits[r] <= cell_bits;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vote_q <= '0;
            id_out <= '0;
            done   <= 1'b0;
        end else begin
            if (vote_en) begin
                vote_q <= maj_w;
            end
            if (finish) begin
                id_out <= vote_q;
            end
            done <= finish;
        end
    end

endmodule

// File: rtl/puf_id_ctrl_chk.sv
`timescale 1ps/1ps
module puf_id_ctrl_chk #(
    parameter int unsigned ID_W = 48
) (
    input logic            clk,
    input logic            rst,
    input logic            done,
    input logic [ID_W-1:0] id_out,
    input logic            clr_cmd,
    input logic            en_cmd,
    input logic            capture,
    input logic            vote_en
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            a_r1_reset_clear: assert (!done && id_out == '0)
                else $error("R1 outputs not cleared by reset");
        end
    end

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r2_done_after_vote: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(vote_en, 2));

    a_r6_id_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(id_out));

    a_r3_capture_frozen: assert property (@(posedge clk) disable iff (rst)
        capture |-> (!en_cmd && !clr_cmd));

    a_r7_clear_before_count: assert property (@(posedge clk) disable iff (rst)
        $rose(en_cmd) |-> $past(clr_cmd));

endmodule

bind puf_id_ctrl puf_id_ctrl_chk #(.ID_W(ID_W)) chk_i (
    .clk(clk), .rst(rst), .done(done), .id_out(id_out),
    .clr_cmd(clr_w), .en_cmd(en_w), .capture(capture), .vote_en(vote_en)
);

// File: tb/puf_id_ctrl_tb_top.sv
`timescale 1ps/1ps
module puf_id_ctrl_tb_top;

    localparam int CLK_PERIOD = 10000;
    localparam int ID_W       = 48;
    localparam int EVAL_LEN   = 256;
    localparam int GEN_CYC    = 770;
    localparam int FAST_HALF  = 2000;
    localparam int SLOW_HALF  = 2500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic done;
    logic [ID_W-1:0] id_out;

    logic osc_a_u [ID_W] = '{default: 1'b0};
    logic osc_b_u [ID_W] = '{default: 1'b0};
    int   half_a  [ID_W] = '{default: FAST_HALF};
    int   half_b  [ID_W] = '{default: SLOW_HALF};
    logic [ID_W-1:0] tie_m = '0;
    logic [ID_W-1:0] osc_a;
    logic [ID_W-1:0] osc_b;

    for (genvar j = 0; j < ID_W; j++) begin : g_osc
        always begin
            #(half_a[j]);
            osc_a_u[j] = ~osc_a_u[j];
        end
        always begin
            #(half_b[j]);
            osc_b_u[j] = ~osc_b_u[j];
        end
        assign osc_a[j] = osc_a_u[j];
        assign osc_b[j] = tie_m[j] ? osc_a_u[j] : osc_b_u[j];
    end

    always #(CLK_PERIOD / 2) clk = ~clk;

    puf_id_ctrl dut_i (
        .clk(clk), .rst(rst), .req(req), .osc_a(osc_a), .osc_b(osc_b),
        .done(done), .id_out(id_out)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [ID_W-1:0] exp_run [3];
    logic [ID_W-1:0] exp_final = '0;

    // Behavioural reference: edge counting from the accepted request.
    logic m_busy = 1'b0;
    logic m_done = 1'b0;
    logic [ID_W-1:0] m_id = '0;
    int   m_k = 0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            m_busy = 1'b0;
            m_done = 1'b0;
            m_id   = '0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_k = m_k + 1;
                if (m_k == GEN_CYC) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                    m_id   = exp_final;
                end
            end else if (req) begin
                m_busy = 1'b1;
                m_k    = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (done !== m_done) begin
                errors++;
                $display("FAIL R2 cycle %0d done act %0b exp %0b", cyc, done, m_done);
            end
            checks++;
            if (id_out !== m_id) begin
                errors++;
                $display("FAIL R6 cycle %0d id_out act %h exp %h", cyc, id_out, m_id);
            end
        end
    end

    function automatic logic mix_bit(input int p, input int r);
        case (p)
            0:       return r != 0;
            1:       return r == 0;
            2:       return r != 1;
            default: return r == 2;
        endcase
    endfunction

    // kind: 0 first faster (1), 1 second faster (0), 2 tie (0)
    task automatic set_pair(input int j, input int kind, input int r);
        tie_m[j] = (kind == 2);
        case (kind)
            0: begin half_a[j] = FAST_HALF; half_b[j] = SLOW_HALF; exp_run[r][j] = 1'b1; end
            1: begin half_a[j] = SLOW_HALF; half_b[j] = FAST_HALF; exp_run[r][j] = 1'b0; end
            default: begin half_a[j] = FAST_HALF; half_b[j] = FAST_HALF; exp_run[r][j] = 1'b0; end
        endcase
    endtask

    task automatic apply_run(input int g, input int r);
        for (int j = 0; j < ID_W; j++) begin
            case (g)
                0:       set_pair(j, j % 3, r);
                1:       set_pair(j, mix_bit(j % 4, r) ? 0 : 1, r);
                default: set_pair(j, (j % 2 == 0) ? 0 : 1, r);
            endcase
        end
        if (r == 2) begin
            for (int j = 0; j < ID_W; j++) begin
                exp_final[j] = (exp_run[0][j] & exp_run[1][j]) | (exp_run[0][j] & exp_run[2][j])
                             | (exp_run[1][j] & exp_run[2][j]);
            end
        end
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic check_mask(input string tag, input logic [ID_W-1:0] mask);
        checks++;
        if ((id_out & mask) !== (exp_final & mask)) begin
            errors++;
            $display("FAIL %s id_out act %h exp %h", tag, id_out & mask, exp_final & mask);
        end
    endtask

    task automatic run_gen(input int g, input bit stray);
        int c0;
        apply_run(g, 0);
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        c0 = cyc;
        wait_cyc(c0 + EVAL_LEN + 4);
        apply_run(g, 1);
        if (stray) begin
            req = 1'b1;          // R6: request during a generation is ignored
            @(negedge clk);
            req = 1'b0;
        end
        wait_cyc(c0 + 2 * EVAL_LEN + 4);
        apply_run(g, 2);
        wait_cyc(c0 + GEN_CYC);
        checks++;
        if (done !== 1'b1) begin
            errors++;
            $display("FAIL R2 done at edge 770 act %0b exp 1", done);
        end
    endtask

    function automatic logic [ID_W-1:0] mod_mask(input int m, input int v);
        logic [ID_W-1:0] k;
        for (int j = 0; j < ID_W; j++) k[j] = (j % m == v);
        return k;
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || id_out !== '0) begin
            errors++;
            $display("FAIL R1 reset done %0b id %h exp 0 0", done, id_out);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || id_out !== '0) begin
            errors++;
            $display("FAIL R1 after reset done %0b id %h exp 0 0", done, id_out);
        end

        // Same ordering in all three runs.
        run_gen(0, 1'b0);
        check_mask("R3 first-faster bits", mod_mask(3, 0));
        check_mask("R3 second-faster bits", mod_mask(3, 1));
        check_mask("R4 tie bits", mod_mask(3, 2));

        // Ordering varies per run; majority decides.
        run_gen(1, 1'b1);
        check_mask("R7 reversed-after-first-run bits", mod_mask(4, 0));
        check_mask("R5 one-of-three bits", mod_mask(4, 1));
        check_mask("R5 split bits", mod_mask(4, 2));
        check_mask("R5 last-only bits", mod_mask(4, 3));

        repeat (120) @(negedge clk);
        checks++;
        if (done !== 1'b0 || id_out !== exp_final) begin
            errors++;
            $display("FAIL R6 hold id act %h exp %h", id_out, exp_final);
        end

        run_gen(2, 1'b0);
        check_mask("R3 alternating word", '1);
        repeat (10) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

endmodule